// File: doc/BRIEF.md
# Selectable-Order Burst Address Sequencer

This block produces the two lowest address bits for a four-beat memory burst. A load cycle captures a starting offset from the low address inputs. Each following advance cycle moves to the next beat. The beat order is either linear (wrapping increment) or interleaved (XOR with the beat index). A mode pin selects the order. That pin is wired statically, so it is treated as a level and is never sampled by the clock.

A single strobe selects between loading and advancing. The register state changes only on a rising clock edge with clock enable high. A flag marks the fourth beat of the burst. The next advance after that flag returns to the starting offset. Higher address bits and the storage access itself belong to the surrounding logic.

Top module: `burst_seq_top`

## Requirements
- R1: While the active-low reset is asserted, and after it is released, the burst address is 00 and the last-beat flag is 0 until the first enabled clock edge.
- R2: On a rising edge with clock enable high and the load strobe high (1 = load, 0 = advance), the burst address becomes the sampled low address bits, the beat index restarts at 0 and the last-beat flag is 0.
- R3: With the mode pin low (linear order), the burst address equals the start value plus the beat index, modulo four.
- R4: With the mode pin high (interleaved order), the burst address equals the start value XOR the beat index. For example, start 01 gives 01, 00, 11, 10.
- R5: On a rising edge with clock enable low, neither the start value nor the beat index changes, whatever the load strobe and address inputs carry.
- R6: The last-beat flag is 1 exactly while the beat index is 3, which is the fourth beat of the burst.
- R7: An advance from the fourth beat returns the beat index to 0, so the burst address is the start value again and the flag drops.
- R8: The mode pin acts combinationally. Changing it between clock edges changes the burst address at once, with no clock edge needed.
- R9: A load during a burst abandons that burst and starts a new one from the newly sampled offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEn | input | 1 | Clock enable; 0 freezes the state |
| loadSel | input | 1 | 1 = load start offset, 0 = advance one beat |
| addrLow | input | 2 | Low address bits captured on a load |
| orderSel | input | 1 | Static order select: 0 linear, 1 interleaved |
| burstAddr | output | 2 | Current low address of the burst |
| lastBeat | output | 1 | High on the fourth beat |

## Verification
The bench runs bursts from several start offsets in both orders. An interleaved design built as an increment, or the reverse, therefore gives a wrong second beat. The wrap after the fourth beat is checked, because a counter that saturates or flags the wrong beat would stick or raise the flag early. Enable-low cycles with live load strobes and changing addresses show whether a design lets a gated edge reload or step. A mid-burst load shows whether the beat index is cleared. A mode flip with no clock edge shows whether the order select was wrongly registered.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } seqStrobe_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkEn,
  input  logic       loadSel,
  output seqStrobe_t strobe
);
  always_comb begin
    strobe.load = clkEn && loadSel;
    strobe.step = clkEn && !loadSel;
  end

  // R5
  gated_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |-> !strobe.load && !strobe.step);

  // R2
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load && strobe.step));
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [BEAT_W-1:0] addrIn,
  input  logic              orderSel,
  output logic [BEAT_W-1:0] burstAddr,
  output logic              lastBeat
);
  localparam int BEATS = 1 << BEAT_W;
  localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(BEATS - 1);

  logic [BEAT_W-1:0] startReg;
  logic [BEAT_W-1:0] beatCnt;
  logic [BEAT_W-1:0] linAddr;
  logic [BEAT_W-1:0] ilvAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startReg <= '0;
      beatCnt  <= '0;
    end else if (strobe.load) begin
      startReg <= addrIn;
      beatCnt  <= '0;
    end else if (strobe.step) begin
      beatCnt  <= beatCnt + 1'b1;
    end
  end

  always_comb begin
    linAddr   = startReg + beatCnt;
    ilvAddr   = startReg ^ beatCnt;
    burstAddr = orderSel ? ilvAddr : linAddr;
    lastBeat  = (beatCnt == LAST_IDX);
  end

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> beatCnt == '0 && startReg == $past(addrIn));

  // R5
  hold_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load && !strobe.step |=> $stable(startReg) && $stable(beatCnt));

  // R7
  wrap_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step && beatCnt == LAST_IDX |=> beatCnt == '0 && !lastBeat);

  // R6
  last_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step && beatCnt == LAST_IDX - 1'b1 |=> lastBeat);

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !orderSel) ##1 !orderSel |->
      burstAddr == BEAT_W'($past(burstAddr) + 1'b1));
endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkEn,
  input  logic       loadSel,
  input  logic [1:0] addrLow,
  input  logic       orderSel,
  output logic [1:0] burstAddr,
  output logic       lastBeat
);
  import burst_seq_pkg::*;

  seqStrobe_t strobe;

  burst_seq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .clkEn   (clkEn),
    .loadSel (loadSel),
    .strobe  (strobe)
  );

  burst_seq_dp #(.BEAT_W(2)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .addrIn    (addrLow),
    .orderSel  (orderSel),
    .burstAddr (burstAddr),
    .lastBeat  (lastBeat)
  );
endmodule

// File: tb/burst_seq_top_test.sv
module burst_seq_top_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clkEn = 1'b0;
  logic       loadSel = 1'b0;
  logic [1:0] addrLow = 2'b00;
  logic       orderSel = 1'b0;
  logic [1:0] burstAddr;
  logic       lastBeat;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  burst_seq_top uut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .loadSel(loadSel),
    .addrLow(addrLow), .orderSel(orderSel),
    .burstAddr(burstAddr), .lastBeat(lastBeat)
  );

  // {req[3:0], en, load, addr[1:0], order, expAddr[1:0], expLast}
  localparam logic [11:0] VEC [0:20] = '{
    {4'd2, 1'b1, 1'b1, 2'b10, 1'b0, 2'b10, 1'b0}, // R2 load start 2
    {4'd3, 1'b1, 1'b0, 2'b00, 1'b0, 2'b11, 1'b0}, // R3 linear
    {4'd3, 1'b1, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0}, // R3
    {4'd6, 1'b1, 1'b0, 2'b00, 1'b0, 2'b01, 1'b1}, // R6 fourth beat
    {4'd7, 1'b1, 1'b0, 2'b00, 1'b0, 2'b10, 1'b0}, // R7 wrap
    {4'd2, 1'b1, 1'b1, 2'b01, 1'b1, 2'b01, 1'b0}, // R2 load start 1
    {4'd4, 1'b1, 1'b0, 2'b00, 1'b1, 2'b00, 1'b0}, // R4 interleaved
    {4'd4, 1'b1, 1'b0, 2'b00, 1'b1, 2'b11, 1'b0}, // R4
    {4'd6, 1'b1, 1'b0, 2'b00, 1'b1, 2'b10, 1'b1}, // R6
    {4'd7, 1'b1, 1'b0, 2'b00, 1'b1, 2'b01, 1'b0}, // R7
    {4'd5, 1'b0, 1'b1, 2'b11, 1'b1, 2'b01, 1'b0}, // R5 gated load
    {4'd5, 1'b0, 1'b0, 2'b10, 1'b1, 2'b01, 1'b0}, // R5 gated advance
    {4'd4, 1'b1, 1'b0, 2'b00, 1'b1, 2'b00, 1'b0}, // R4
    {4'd9, 1'b1, 1'b1, 2'b11, 1'b0, 2'b11, 1'b0}, // R9 mid-burst load
    {4'd3, 1'b1, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0}, // R3
    {4'd2, 1'b1, 1'b1, 2'b11, 1'b1, 2'b11, 1'b0}, // R2
    {4'd4, 1'b1, 1'b0, 2'b00, 1'b1, 2'b10, 1'b0}, // R4
    {4'd4, 1'b1, 1'b0, 2'b00, 1'b1, 2'b01, 1'b0}, // R4
    {4'd6, 1'b1, 1'b0, 2'b00, 1'b1, 2'b00, 1'b1}, // R6
    {4'd5, 1'b0, 1'b0, 2'b00, 1'b1, 2'b00, 1'b1}, // R5 hold on last beat
    {4'd7, 1'b1, 1'b0, 2'b00, 1'b1, 2'b11, 1'b0}  // R7
  };

  task automatic check(input int req, input logic [1:0] actA, input logic actL,
                       input logic [1:0] expA, input logic expL);
    checks++;
    if (actA !== expA || actL !== expL) begin
      errors++;
      $display("FAIL R%0d: actual addr=%b last=%b expected addr=%b last=%b",
               req, actA, actL, expA, expL);
    end
  endtask

  initial begin
    #40000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    #3 check(1, burstAddr, lastBeat, 2'b00, 1'b0);
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(1, burstAddr, lastBeat, 2'b00, 1'b0);

    for (int i = 0; i < 21; i++) begin
      @(negedge clk);
      clkEn    = VEC[i][7];
      loadSel  = VEC[i][6];
      addrLow  = VEC[i][5:4];
      orderSel = VEC[i][3];
      @(posedge clk);
      #2;
      check(int'(VEC[i][11:8]), burstAddr, lastBeat, VEC[i][2:1], VEC[i][0]);
    end

    // R8: order pin acts without a clock edge
    @(negedge clk);
    clkEn = 1'b1; loadSel = 1'b1; addrLow = 2'b01; orderSel = 1'b0;
    @(posedge clk); #2;
    check(2, burstAddr, lastBeat, 2'b01, 1'b0);
    @(negedge clk);
    loadSel = 1'b0;
    @(posedge clk); #1;
    clkEn = 1'b0;
    #1 check(3, burstAddr, lastBeat, 2'b10, 1'b0);
    orderSel = 1'b1;
    #1 check(8, burstAddr, lastBeat, 2'b00, 1'b0);
    orderSel = 1'b0;
    #1 check(8, burstAddr, lastBeat, 2'b10, 1'b0);

    // R1: asynchronous reset in mid-burst
    #1 rstN = 1'b0;
    #1 check(1, burstAddr, lastBeat, 2'b00, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule